// File: doc/BRIEF.md
# Z80 Bus Cycle Capture Classifier

This block sits beside a Z80-style backplane and produces one trace record for every memory or I/O bus cycle that completes. It samples the bus with its own free-running clock, which must run at least four times faster than the bus clock. Every bus line passes through a synchroniser. The block then watches the memory-request and I/O-request strobes for their deasserting (low-to-high) transition. At that transition it builds a record from the address, the data and the control lines. All of these are taken from the last sample before the strobe rose. This matters because the write and opcode-fetch lines may already have changed by the time the strobe goes inactive.

Each record carries a flag that tells I/O cycles from memory cycles, a four-bit status field, the data byte and the address. A separate three-bit code gives the cycle type. A control input can discard refresh cycles before they reach the output. Records leave through a single-entry valid/ready stage. A record that arrives while that stage is stalled is thrown away and counted in a saturating drop counter.

Top module: `z80_cycle_tap`

## Requirements
- R1: A low-to-high transition of `bus_mreq_n` or `bus_iorq_n` yields exactly one record. `rec_valid` rises at the third rising clock edge, counting the first edge that samples the strobe high as the first.
- R2: `rec_data` layout: bit 28 is 1 for an I/O cycle and 0 for a memory cycle, bits 27:24 are the status field, bits 23:16 are the data byte and bits 15:0 are the address.
- R3: Status bits are: bit 27 = 1 when write was active (`bus_wr_n` low), bit 26 = level of `bus_iorq_n`, bit 25 = level of `bus_rfsh_n`, bit 24 = level of `bus_m1_n`. All are taken before the edge.
- R4: For a memory cycle, `rec_kind` is chosen by priority: write gives 1, then opcode fetch (M1 low) gives 2, then refresh (RFSH low) gives 3. Otherwise it is a memory read and gives 0.
- R5: For an I/O cycle, `rec_kind` is chosen by priority: write gives 5, then interrupt acknowledge (M1 low) gives 6. Otherwise it is a port read and gives 4.
- R6: Address, data and control values come from the last sample before the strobe was seen high. Changes made at the same moment the strobe rises do not appear in the record.
- R7: While `drop_refresh` is 1, a refresh cycle (kind 3) produces no record and does not count as a drop. Other cycles still pass. While it is 0, refresh cycles are emitted.
- R8: While `rec_valid` is 1 and `rec_ready` is 0, the record and its kind are held unchanged. After a transfer with no new record waiting, `rec_valid` returns to 0.
- R9: A record that arrives while the output is stalled is discarded. `drop_count` then increments by one and saturates at all ones.
- R10: Synchronous reset clears `rec_valid` and `drop_count`. A strobe that is first sampled high within the first two clock cycles after reset produces no record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, at least 4x the bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 16 | Address lines |
| bus_data | input | 8 | Data lines |
| bus_mreq_n | input | 1 | Memory request strobe, active low |
| bus_iorq_n | input | 1 | I/O request strobe, active low |
| bus_wr_n | input | 1 | Write strobe, active low |
| bus_m1_n | input | 1 | Opcode fetch / acknowledge marker, active low |
| bus_rfsh_n | input | 1 | Refresh marker, active low |
| drop_refresh | input | 1 | 1 = discard refresh cycles |
| rec_ready | input | 1 | Downstream accepts the record |
| rec_valid | output | 1 | Record available |
| rec_data | output | 29 | Captured record (layout in R2) |
| rec_kind | output | 3 | Cycle type code (R4, R5) |
| drop_count | output | DROP_W (16) | Saturating count of discarded records |

## Verification
The hardest case to reach is a strobe that rises only a cycle or two after reset is released. The synchroniser reset values would normally hide it, so the bench holds the memory strobe low through reset and raises it one cycle after release. This shows that the start-up guard suppresses the record, and a normal cycle afterwards proves that the block then arms itself. The other difficult case is a stalled output: the bench keeps `rec_ready` low across many bus cycles. This drives the drop counter into saturation and shows that the held record never changes. Refresh filtering is also checked against a stalled slot.

// File: rtl/zbt_pkg.sv
package zbt_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam int STAT_W = 4;
    localparam int KIND_W = 3;
    localparam int REC_W  = 1 + STAT_W + DATA_W + ADDR_W;

    typedef enum logic [KIND_W-1:0] {
        K_MEM_RD  = 3'd0,
        K_MEM_WR  = 3'd1,
        K_FETCH   = 3'd2,
        K_REFRESH = 3'd3,
        K_IO_RD   = 3'd4,
        K_IO_WR   = 3'd5,
        K_INTA    = 3'd6
    } cyc_kind_e;

    // One synchronised snapshot of the monitored bus lines.
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic              mreq_n;
        logic              iorq_n;
        logic              wr_n;
        logic              m1_n;
        logic              rfsh_n;
    } bus_smp_t;

    localparam int SMP_W = $bits(bus_smp_t);

    localparam bus_smp_t SMP_IDLE = '{
        addr:   '0,
        data:   '0,
        mreq_n: 1'b1,
        iorq_n: 1'b1,
        wr_n:   1'b1,
        m1_n:   1'b1,
        rfsh_n: 1'b1
    };

    // Outgoing trace record; the packed order is the port layout.
    typedef struct packed {
        logic              is_io;
        logic [STAT_W-1:0] status;
        logic [DATA_W-1:0] data;
        logic [ADDR_W-1:0] addr;
    } rec_t;

    function automatic logic [STAT_W-1:0] pack_status(input bus_smp_t s);
        return {~s.wr_n, s.iorq_n, s.rfsh_n, s.m1_n};
    endfunction

    function automatic cyc_kind_e classify(input logic is_io, input logic wr_n,
                                           input logic m1_n, input logic rfsh_n);
        cyc_kind_e k;
        if (is_io) begin
            if (!wr_n)      k = K_IO_WR;
            else if (!m1_n) k = K_INTA;
            else            k = K_IO_RD;
        end else begin
            if (!wr_n)        k = K_MEM_WR;
            else if (!m1_n)   k = K_FETCH;
            else if (!rfsh_n) k = K_REFRESH;
            else              k = K_MEM_RD;
        end
        return k;
    endfunction

endpackage

// File: rtl/zbt_sync.sv
module zbt_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[i] <= RST_VAL;
                else     stg[i] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg[i] <= RST_VAL;
                else     stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/zbt_cycle_detect.sv
module zbt_cycle_detect
    import zbt_pkg::*;
#(
    parameter int GUARD_CYC   = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      cur_mreq_n,
    input  logic      cur_iorq_n,
    input  bus_smp_t  prev,
    input  logic      drop_refresh,
    output logic      hit,
    output rec_t      rec,
    output cyc_kind_e kind
);

    // Pipeline depth from pin to edge detection plus the guard window.
    localparam int SETTLE = GUARD_CYC + SYNC_STAGES + 1;
    localparam int WARM_W = $clog2(SETTLE + 1);

    logic [WARM_W-1:0] warm;
    logic              armed;
    logic              mem_rise;
    logic              io_rise;

    assign armed = (warm == WARM_W'(SETTLE));

    always_ff @(posedge clk) begin
        if (rst)        warm <= '0;
        else if (!armed) warm <= warm + 1'b1;
    end

    assign mem_rise = !prev.mreq_n && cur_mreq_n;
    assign io_rise  = !prev.iorq_n && cur_iorq_n;

    always_comb begin
        rec.is_io  = io_rise;
        rec.status = pack_status(prev);
        rec.data   = prev.data;
        rec.addr   = prev.addr;
        kind       = classify(io_rise, prev.wr_n, prev.m1_n, prev.rfsh_n);
        hit        = armed && (mem_rise || io_rise)
                     && !(drop_refresh && kind == K_REFRESH);
    end

endmodule

// File: rtl/zbt_out_slot.sv
module zbt_out_slot
    import zbt_pkg::*;
#(
    parameter int DROP_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_hit,
    input  rec_t              in_rec,
    input  cyc_kind_e         in_kind,
    input  logic              ready,
    output logic              valid,
    output rec_t              rec,
    output cyc_kind_e         kind,
    output logic [DROP_W-1:0] drops
);

    localparam logic [DROP_W-1:0] DROP_MAX = '1;

    logic take;
    logic lost;

    assign take = in_hit && (!valid || ready);
    assign lost = in_hit && valid && !ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            rec   <= '0;
            kind  <= K_MEM_RD;
        end else if (take) begin
            valid <= 1'b1;
            rec   <= in_rec;
            kind  <= in_kind;
        end else if (ready) begin
            valid <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                            drops <= '0;
        else if (lost && drops != DROP_MAX) drops <= drops + 1'b1;
    end

endmodule

// File: rtl/z80_cycle_tap.sv
module z80_cycle_tap
    import zbt_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int GUARD_CYC   = 2,
    parameter int DROP_W      = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_data,
    input  logic              bus_mreq_n,
    input  logic              bus_iorq_n,
    input  logic              bus_wr_n,
    input  logic              bus_m1_n,
    input  logic              bus_rfsh_n,
    input  logic              drop_refresh,
    input  logic              rec_ready,
    output logic              rec_valid,
    output logic [REC_W-1:0]  rec_data,
    output logic [KIND_W-1:0] rec_kind,
    output logic [DROP_W-1:0] drop_count
);

    bus_smp_t  raw;
    bus_smp_t  cur;
    bus_smp_t  prev;
    logic      det_hit;
    rec_t      det_rec;
    cyc_kind_e det_kind;
    rec_t      slot_rec;
    cyc_kind_e slot_kind;

    always_comb begin
        raw.addr   = bus_addr;
        raw.data   = bus_data;
        raw.mreq_n = bus_mreq_n;
        raw.iorq_n = bus_iorq_n;
        raw.wr_n   = bus_wr_n;
        raw.m1_n   = bus_m1_n;
        raw.rfsh_n = bus_rfsh_n;
    end

    zbt_sync #(
        .W       (SMP_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (SMP_IDLE)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw),
        .q   (cur)
    );

    // One extra sample of history: the values seen just before an edge.
    zbt_sync #(
        .W       (SMP_W),
        .STAGES  (1),
        .RST_VAL (SMP_IDLE)
    ) u_hist (
        .clk (clk),
        .rst (rst),
        .d   (cur),
        .q   (prev)
    );

    zbt_cycle_detect #(
        .GUARD_CYC   (GUARD_CYC),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_detect (
        .clk          (clk),
        .rst          (rst),
        .cur_mreq_n   (cur.mreq_n),
        .cur_iorq_n   (cur.iorq_n),
        .prev         (prev),
        .drop_refresh (drop_refresh),
        .hit          (det_hit),
        .rec          (det_rec),
        .kind         (det_kind)
    );

    zbt_out_slot #(
        .DROP_W (DROP_W)
    ) u_slot (
        .clk     (clk),
        .rst     (rst),
        .in_hit  (det_hit),
        .in_rec  (det_rec),
        .in_kind (det_kind),
        .ready   (rec_ready),
        .valid   (rec_valid),
        .rec     (slot_rec),
        .kind    (slot_kind),
        .drops   (drop_count)
    );

    assign rec_data = slot_rec;
    assign rec_kind = slot_kind;

endmodule

// File: rtl/zbt_cycle_tap_chk.sv
module zbt_cycle_tap_chk #(
    parameter int DROP_W = 16,
    parameter int REC_W  = 29
) (
    input logic              clk,
    input logic              rst,
    input logic              drop_refresh,
    input logic              rec_ready,
    input logic              rec_valid,
    input logic [REC_W-1:0]  rec_data,
    input logic [2:0]        rec_kind,
    input logic [DROP_W-1:0] drop_count
);

    p_hold_stalled_r8: assert property (@(posedge clk) disable iff (rst)
        (rec_valid && !rec_ready) |=> (rec_valid && $stable(rec_data) && $stable(rec_kind)));

    p_drop_step_r9: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (drop_count == $past(drop_count)
                         || drop_count == $past(drop_count) + 1'b1));

    p_drop_saturate_r9: assert property (@(posedge clk) disable iff (rst)
        (drop_count == {DROP_W{1'b1}}) |=> (drop_count == {DROP_W{1'b1}}));

    p_quiet_after_reset_r10: assert property (@(posedge clk)
        rst |=> !rec_valid);

    p_kind_matches_flag_r5: assert property (@(posedge clk) disable iff (rst)
        rec_valid |-> ((rec_kind >= 3'd4) == rec_data[REC_W-1]));

    p_refresh_filtered_r7: assert property (@(posedge clk) disable iff (rst)
        ($rose(rec_valid) && $past(drop_refresh)) |-> (rec_kind != 3'd3));

endmodule

bind z80_cycle_tap zbt_cycle_tap_chk #(
    .DROP_W (DROP_W),
    .REC_W  (zbt_pkg::REC_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .drop_refresh (drop_refresh),
    .rec_ready    (rec_ready),
    .rec_valid    (rec_valid),
    .rec_data     (rec_data),
    .rec_kind     (rec_kind),
    .drop_count   (drop_count)
);

// File: tb/z80_cycle_tap_tb_top.sv
module z80_cycle_tap_tb_top;

    localparam int DW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [15:0]   bus_addr = '0;
    logic [7:0]    bus_data = '0;
    logic          bus_mreq_n = 1'b1;
    logic          bus_iorq_n = 1'b1;
    logic          bus_wr_n = 1'b1;
    logic          bus_m1_n = 1'b1;
    logic          bus_rfsh_n = 1'b1;
    logic          drop_refresh = 1'b0;
    logic          rec_ready = 1'b0;
    logic          rec_valid;
    logic [28:0]   rec_data;
    logic [2:0]    rec_kind;
    logic [DW-1:0] drop_count;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    z80_cycle_tap #(.DROP_W(DW)) dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_data(bus_data),
        .bus_mreq_n(bus_mreq_n), .bus_iorq_n(bus_iorq_n), .bus_wr_n(bus_wr_n),
        .bus_m1_n(bus_m1_n), .bus_rfsh_n(bus_rfsh_n), .drop_refresh(drop_refresh),
        .rec_ready(rec_ready), .rec_valid(rec_valid), .rec_data(rec_data),
        .rec_kind(rec_kind), .drop_count(drop_count)
    );

    // Vector fields: [27] io, [26] write, [25] m1, [24] refresh, [23:8] addr, [7:0] data
    localparam logic [27:0] VEC [8] = '{
        {1'b0, 1'b0, 1'b0, 1'b0, 16'h1234, 8'h5A},
        {1'b0, 1'b1, 1'b0, 1'b0, 16'hFFFF, 8'hA5},
        {1'b0, 1'b0, 1'b1, 1'b0, 16'h0000, 8'h3E},
        {1'b0, 1'b0, 1'b0, 1'b1, 16'h007F, 8'hFF},
        {1'b0, 1'b1, 1'b1, 1'b0, 16'h8001, 8'h01},
        {1'b1, 1'b0, 1'b0, 1'b0, 16'h00FE, 8'h10},
        {1'b1, 1'b1, 1'b0, 1'b0, 16'h0138, 8'hC3},
        {1'b1, 1'b0, 1'b1, 1'b0, 16'h0038, 8'hFF}
    };

    function automatic logic [28:0] exp_rec(input logic [27:0] v);
        return {v[27], v[26], ~v[27], ~v[24], ~v[25], v[7:0], v[23:8]};
    endfunction

    function automatic logic [2:0] exp_kind(input logic [27:0] v);
        if (v[27]) return v[26] ? 3'd5 : (v[25] ? 3'd6 : 3'd4);
        return v[26] ? 3'd1 : (v[25] ? 3'd2 : (v[24] ? 3'd3 : 3'd0));
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drives a cycle; returns at the negedge where the strobe rises and the
    // controls, address and data change at the same moment.
    task automatic start_cycle(input logic [27:0] v);
        bus_addr   = v[23:8];
        bus_data   = v[7:0];
        bus_wr_n   = ~v[26];
        bus_m1_n   = ~v[25];
        bus_rfsh_n = ~v[24];
        if (v[27]) bus_iorq_n = 1'b0; else bus_mreq_n = 1'b0;
        tick(3);
        bus_mreq_n = 1'b1;
        bus_iorq_n = 1'b1;
        bus_wr_n   = 1'b1;
        bus_m1_n   = 1'b1;
        bus_rfsh_n = 1'b1;
        bus_addr   = ~v[23:8];
        bus_data   = ~v[7:0];
    endtask

    task automatic full_cycle(input logic [27:0] v);
        start_cycle(v);
        tick(6);
    endtask

    task automatic pop();
        rec_ready = 1'b1;
        tick(1);
        rec_ready = 1'b0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    localparam logic [27:0] RD_A  = {1'b0, 1'b0, 1'b0, 1'b0, 16'hBEEF, 8'h77};
    localparam logic [27:0] RD_B  = {1'b0, 1'b0, 1'b0, 1'b0, 16'h4321, 8'h12};
    localparam logic [27:0] RFSH  = {1'b0, 1'b0, 1'b0, 1'b1, 16'h0011, 8'h00};

    initial begin
        tick(3);
        rst = 1'b0;
        tick(1);
        check("R10 reset valid", 32'(rec_valid), 32'd0);
        check("R10 reset drops", 32'(drop_count), 32'd0);
        tick(8);

        // Table walk: latency, layout, kind, single record per cycle.
        for (int i = 0; i < 8; i++) begin
            start_cycle(VEC[i]);
            tick(2);
            check("R1 not yet valid", 32'(rec_valid), 32'd0);
            tick(1);
            check("R1 valid on third edge", 32'(rec_valid), 32'd1);
            check("R2 R3 R6 record", 32'(rec_data), 32'(exp_rec(VEC[i])));
            check("R4 R5 kind", 32'(rec_kind), 32'(exp_kind(VEC[i])));
            tick(3);
            pop();
            tick(3);
            check("R1 one record only", 32'(rec_valid), 32'd0);
        end

        // Refresh filtering.
        drop_refresh = 1'b1;
        full_cycle(RFSH);
        check("R7 refresh suppressed", 32'(rec_valid), 32'd0);
        full_cycle(RD_A);
        check("R7 read passes", 32'(rec_valid), 32'd1);
        check("R7 read kind", 32'(rec_kind), 32'd0);
        full_cycle(RFSH);
        check("R7 suppressed not a drop", 32'(drop_count), 32'd0);
        drop_refresh = 1'b0;

        // Stalled output: drops and hold.
        full_cycle(RD_B);
        check("R9 first drop", 32'(drop_count), 32'd1);
        check("R8 record held", 32'(rec_data), 32'(exp_rec(RD_A)));
        for (int j = 0; j < 16; j++) full_cycle(RD_B);
        check("R9 saturated", 32'(drop_count), 32'd15);
        check("R8 still held", 32'(rec_data), 32'(exp_rec(RD_A)));
        pop();
        check("R8 cleared after transfer", 32'(rec_valid), 32'd0);
        tick(4);

        // Refresh emitted when filter off.
        full_cycle(RFSH);
        check("R7 refresh emitted", 32'(rec_kind), 32'd3);
        check("R7 refresh valid", 32'(rec_valid), 32'd1);

        // Reset clears state; early strobe ignored.
        rst        = 1'b1;
        bus_mreq_n = 1'b0;
        tick(3);
        check("R10 reset clears drops", 32'(drop_count), 32'd0);
        check("R10 reset clears valid", 32'(rec_valid), 32'd0);
        rst = 1'b0;
        tick(1);
        bus_mreq_n = 1'b1;
        tick(8);
        check("R10 early strobe ignored", 32'(rec_valid), 32'd0);
        full_cycle(RD_B);
        check("R10 armed afterwards", 32'(rec_valid), 32'd1);
        check("R10 armed record", 32'(rec_data), 32'(exp_rec(RD_B)));

        done = 1'b1;
        summary();
        $finish;
    end

endmodule